// File: doc/BRIEF.md
# Two-Wire Bus Status Monitor

This block sits beside a two-wire (I2C-style) bus and tracks bus activity for a CPU. It synchronizes the clock (SCL) and data (SDA) lines, recognizes START and STOP conditions, counts clock pulses within each byte, and keeps an eight-bit status word. That word holds a transfer-complete flag, an addressed-as-slave flag, bus-busy, arbitration-lost, the slave read/write direction, an interrupt flag and the last received acknowledge bit.

The CPU reads the status word through a small register port, clears the two software-clearable flags by writing zeros to them, and signals control-register writes through a strobe. The strobe drops the addressed-as-slave flag. Arbitration loss is reported to the block as a one-cycle pulse from the bus master logic. An interrupt line is raised while the interrupt flag is set and interrupts are enabled.

Top module: `twowire_stat_mon`

## Requirements
- R1: After reset the status word reads 0x81 (transfer-complete and received-acknowledge at 1, every other bit 0) and irq is 0.
- R2: Bus-busy (bit 5) sets when SDA falls while SCL is high (START) and clears when SDA rises while SCL is high (STOP).
- R3: Transfer-complete (bit 7) clears on the first SCL rising edge of a byte and sets on the falling edge of the ninth SCL clock of that byte.
- R4: Received-acknowledge (bit 0) takes the SDA level sampled at the ninth SCL rising edge; 1 means no acknowledge.
- R5: Slave read/write (bit 2) takes the eighth bit of the first byte after a START.
- R6: Addressed-as-slave (bit 6) sets when the first seven bits of the first byte after a START (MSB first) equal own_addr. Later bytes never set it. Any ctrl_wr pulse clears it.
- R7: Arbitration-lost (bit 4) sets on an arb_lost_pulse and clears only on a status write with wdata bit 4 at 0.
- R8: The interrupt flag (bit 1) sets when transfer-complete sets, when addressed-as-slave sets, or on arb_lost_pulse. A status write with wdata bit 1 at 0 clears it, and writing 1 leaves it unchanged.
- R9: irq is high exactly when the interrupt flag is 1 and irq_en is 1.
- R10: The status word is at reg_addr 0x1B, and its bit 3 always reads 0. Reads at any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| own_addr | input | 7 | Own slave address |
| irq_en | input | 1 | Interrupt enable |
| arb_lost_pulse | input | 1 | One-cycle arbitration-loss event |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| ctrl_wr | input | 1 | Control-register write strobe |
| stat_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, seven-bit addresses and the status word at offset 0x1B. With these values a full address byte and its acknowledge take only a few hundred clocks, so each table row can run a whole START-to-STOP transaction. A data byte that repeats the own address is also reachable, which shows that only the first byte after a START can match.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

  typedef struct packed {
    logic tc;     // bit 7 transfer complete
    logic aas;    // bit 6 addressed as slave
    logic bb;     // bit 5 bus busy
    logic al;     // bit 4 arbitration lost
    logic rsvd;   // bit 3 reads 0
    logic srw;    // bit 2 slave read/write
    logic iflag;  // bit 1 interrupt flag
    logic rxak;   // bit 0 received acknowledge
  } stat_t;

  localparam stat_t STAT_RESET = '{tc: 1'b1, aas: 1'b0, bb: 1'b0, al: 1'b0,
                                   rsvd: 1'b0, srw: 1'b0, iflag: 1'b0, rxak: 1'b1};

  typedef struct packed {
    logic start;
    logic stop;
    logic byte_begin;
    logic byte_done;
    logic rw_valid;
    logic rw_bit;
    logic ack_valid;
    logic ack_bit;
    logic addr_hit;
  } bus_evt_t;

endpackage

// File: rtl/twsm_sync.sv
module twsm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;   // idle bus lines are high
      else        chain_q <= chain_d;
    end

    assign q[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/twsm_frame.sv
module twsm_frame
  import twsm_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W-1:0] own_addr,
  output bus_evt_t          evt
);
  localparam int DATA_BITS = ADDR_W + 1;
  localparam int LAST_CLK  = DATA_BITS + 1;
  localparam int CW        = $clog2(LAST_CLK + 1);

  logic          prev_scl_q, prev_sda_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d;
  logic [ADDR_W-1:0] sh_q, sh_d;

  logic start_c, stop_c, rise_c, fall_c;

  always_comb begin
    start_c = prev_scl_q & scl & prev_sda_q & ~sda;
    stop_c  = prev_scl_q & scl & ~prev_sda_q & sda;
    rise_c  = ~prev_scl_q & scl;
    fall_c  = prev_scl_q & ~scl;
  end

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    sh_d    = sh_q;
    if (start_c) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (stop_c) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (rise_c) begin
      if (cnt_q < CW'(LAST_CLK)) cnt_d = cnt_q + 1'b1;
      if (cnt_q < CW'(ADDR_W))   sh_d  = {sh_q[ADDR_W-2:0], sda};
    end else if (fall_c && cnt_q == CW'(LAST_CLK)) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end
  end

  always_comb begin
    evt            = '0;
    evt.start      = start_c;
    evt.stop       = stop_c;
    evt.byte_begin = rise_c & (cnt_q == '0);
    evt.byte_done  = fall_c & (cnt_q == CW'(LAST_CLK)) & ~start_c & ~stop_c;
    evt.rw_valid   = rise_c & first_q & (cnt_q == CW'(ADDR_W));
    evt.rw_bit     = sda;
    evt.addr_hit   = rise_c & first_q & (cnt_q == CW'(ADDR_W)) & (sh_q == own_addr);
    evt.ack_valid  = rise_c & (cnt_q == CW'(DATA_BITS));
    evt.ack_bit    = sda;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      sh_q       <= '0;
    end else begin
      prev_scl_q <= scl;
      prev_sda_q <= sda;
      cnt_q      <= cnt_d;
      first_q    <= first_d;
      sh_q       <= sh_d;
    end
  end
endmodule

// File: rtl/twsm_status.sv
module twsm_status
  import twsm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  input  logic     stat_wr,
  input  logic     clr_al_n,
  input  logic     clr_if_n,
  input  logic     ctrl_wr,
  input  logic     al_pulse,
  output stat_t    stat
);
  stat_t st_q, st_d;
  logic  tc_set;

  always_comb begin
    st_d   = st_q;
    tc_set = evt.byte_done & ~st_q.tc;
    // byte progress
    if (evt.byte_begin) st_d.tc = 1'b0;
    if (evt.byte_done)  st_d.tc = 1'b1;
    // bus busy
    if (evt.stop)  st_d.bb = 1'b0;
    if (evt.start) st_d.bb = 1'b1;
    // captured bits
    if (evt.rw_valid)  st_d.srw  = evt.rw_bit;
    if (evt.ack_valid) st_d.rxak = evt.ack_bit;
    // addressed as slave: control write clears, a hit wins
    if (ctrl_wr)      st_d.aas = 1'b0;
    if (evt.addr_hit) st_d.aas = 1'b1;
    // software-clearable flags, set wins
    if (stat_wr && !clr_al_n) st_d.al = 1'b0;
    if (al_pulse)             st_d.al = 1'b1;
    if (stat_wr && !clr_if_n) st_d.iflag = 1'b0;
    if (tc_set || evt.addr_hit || al_pulse) st_d.iflag = 1'b1;
    st_d.rsvd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STAT_RESET;
    else        st_q <= st_d;
  end

  assign stat = st_q;
endmodule

// File: rtl/twowire_stat_mon.sv
module twowire_stat_mon
  import twsm_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 7,
  parameter int                REG_AW      = 8,
  parameter logic [REG_AW-1:0] STAT_OFFSET = 8'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              irq_en,
  input  logic              arb_lost_pulse,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              ctrl_wr,
  output logic [7:0]        stat_rdata,
  output logic              irq
);
  localparam int AL_BIT = 4;
  localparam int IF_BIT = 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [1:0] lines_s;
  twsm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_in, sda_in}), .q(lines_s)
  );

  bus_evt_t evt_w;
  twsm_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .scl(lines_s[1]), .sda(lines_s[0]),
    .own_addr(own_addr), .evt(evt_w)
  );

  logic  sel_stat;
  logic  stat_wr_w;
  logic  addr_hit_w;
  stat_t status_w;

  always_comb begin
    sel_stat   = (reg_addr == STAT_OFFSET);
    stat_wr_w  = reg_wr & sel_stat;
    addr_hit_w = evt_w.addr_hit;
  end

  twsm_status u_status (
    .clk(clk), .rst_n(rst_int_n), .evt(evt_w), .stat_wr(stat_wr_w),
    .clr_al_n(reg_wdata[AL_BIT]), .clr_if_n(reg_wdata[IF_BIT]),
    .ctrl_wr(ctrl_wr), .al_pulse(arb_lost_pulse), .stat(status_w)
  );

  always_comb begin
    stat_rdata = sel_stat ? status_w : 8'h00;
    irq        = status_w.iflag & irq_en;
  end
endmodule

// File: rtl/twsm_chk.sv
module twsm_chk #(
  parameter int                REG_AW      = 8,
  parameter logic [REG_AW-1:0] STAT_OFFSET = 8'h1B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              irq_en,
  input logic              arb_lost_pulse,
  input logic              ctrl_wr,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        status,
  input logic              addr_hit
);
  logic al_clr;
  assign al_clr = reg_wr && (reg_addr == STAT_OFFSET) && !reg_wdata[4];

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_al_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_pulse |=> status[4]);

  assert_al_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !al_clr) |=> status[4]);

  assert_aas_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !addr_hit) |=> !status[6]);

  assert_tc_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> status[1]);
endmodule

bind twowire_stat_mon twsm_chk #(.REG_AW(REG_AW), .STAT_OFFSET(STAT_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en),
  .arb_lost_pulse(arb_lost_pulse), .ctrl_wr(ctrl_wr), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status_w),
  .addr_hit(addr_hit_w)
);

// File: tb/twowire_stat_mon_test.sv
module twowire_stat_mon_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_in, sda_in;
  logic [6:0] own_addr;
  logic       irq_en, arb_lost_pulse;
  logic [7:0] reg_addr, reg_wdata;
  logic       reg_wr, ctrl_wr;
  logic [7:0] stat_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [7:0] STAT = 8'h1B;
  localparam int P = 4;

  // {addr[6:0], rw, ack, own[6:0], expect_aas}
  localparam logic [16:0] VEC [6] = '{
    {7'h2A, 1'b0, 1'b0, 7'h2A, 1'b1},
    {7'h2A, 1'b1, 1'b1, 7'h2B, 1'b0},
    {7'h7F, 1'b1, 1'b0, 7'h7F, 1'b1},
    {7'h00, 1'b0, 1'b1, 7'h01, 1'b0},
    {7'h55, 1'b1, 1'b0, 7'h55, 1'b1},
    {7'h40, 1'b0, 1'b0, 7'h20, 1'b0}
  };

  always #10 clk = ~clk;

  twowire_stat_mon uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .own_addr(own_addr), .irq_en(irq_en), .arb_lost_pulse(arb_lost_pulse),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctrl_wr(ctrl_wr), .stat_rdata(stat_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_in = 1'b1; idle(P); scl_in = 1'b1; idle(P);
    sda_in = 1'b0; idle(P); scl_in = 1'b0; idle(P);
  endtask

  task automatic bus_stop();
    sda_in = 1'b0; idle(P); scl_in = 1'b1; idle(P);
    sda_in = 1'b1; idle(P);
  endtask

  task automatic bus_bit(input logic b);
    sda_in = b; idle(P); scl_in = 1'b1; idle(P); scl_in = 1'b0; idle(P);
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(ack);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = STAT;
    @(negedge clk);
  endtask

  task automatic pulse_ctrl();
    ctrl_wr = 1'b1; @(negedge clk); ctrl_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; own_addr = 7'h2A;
    irq_en = 1'b0; arb_lost_pulse = 1'b0; reg_addr = STAT; reg_wdata = 8'h00;
    reg_wr = 1'b0; ctrl_wr = 1'b0;
    idle(3);
    chk("R1 reset status", stat_rdata, 8'h81);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    idle(6);
    chk("R1 status after release", stat_rdata, 8'h81);
    chk("R10 bit3 reads 0", {7'b0, stat_rdata[3]}, 8'h00);

    // tc clears in the middle of a byte, data byte equal to own address
    own_addr = 7'h2A;
    bus_start();
    chk("R2 busy after START", {7'b0, stat_rdata[5]}, 8'h01);
    bus_bit(1'b0);
    chk("R3 tc low mid byte", {7'b0, stat_rdata[7]}, 8'h00);
    for (int i = 6; i >= 0; i--) bus_bit(i == 0);   // 0x01: address 0x00, read
    chk("R3 tc low before ninth clock", {7'b0, stat_rdata[7]}, 8'h00);
    bus_bit(1'b1);
    chk("R3 tc set after ninth fall", {7'b0, stat_rdata[7]}, 8'h01);
    chk("R4 nack captured", {7'b0, stat_rdata[0]}, 8'h01);
    chk("R5 read bit captured", {7'b0, stat_rdata[2]}, 8'h01);
    chk("R6 no match on address 0", {7'b0, stat_rdata[6]}, 8'h00);
    bus_byte({7'h2A, 1'b0}, 1'b0);
    chk("R6 data byte never matches", {7'b0, stat_rdata[6]}, 8'h00);
    chk("R5 data byte keeps srw", {7'b0, stat_rdata[2]}, 8'h01);
    bus_stop();
    chk("R2 idle after STOP", {7'b0, stat_rdata[5]}, 8'h00);

    // arbitration loss and flag clearing
    wr_reg(STAT, 8'h00);
    chk("R8 flag cleared by 0", {7'b0, stat_rdata[1]}, 8'h00);
    arb_lost_pulse = 1'b1; @(negedge clk); arb_lost_pulse = 1'b0; @(negedge clk);
    chk("R7 al set", {7'b0, stat_rdata[4]}, 8'h01);
    chk("R8 flag set by al", {7'b0, stat_rdata[1]}, 8'h01);
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    wr_reg(STAT, 8'hFF);
    chk("R7 al kept on write 1", {7'b0, stat_rdata[4]}, 8'h01);
    chk("R8 flag kept on write 1", {7'b0, stat_rdata[1]}, 8'h01);
    wr_reg(8'h1C, 8'h00);
    chk("R10 other address write ignored", stat_rdata & 8'h12, 8'h12);
    reg_addr = 8'h1A; @(negedge clk);
    chk("R10 other address reads 0", stat_rdata, 8'h00);
    reg_addr = STAT; @(negedge clk);
    wr_reg(STAT, 8'hEF);
    chk("R7 al cleared by 0", {7'b0, stat_rdata[4]}, 8'h00);
    chk("R8 flag untouched by al clear", {7'b0, stat_rdata[1]}, 8'h01);
    irq_en = 1'b1; @(negedge clk);
    chk("R9 irq follows flag", {7'b0, irq}, 8'h01);
    wr_reg(STAT, 8'hFD);
    chk("R9 irq drops with flag", {7'b0, irq}, 8'h00);

    // table of address transactions
    foreach (VEC[k]) begin
      logic [6:0] a;
      logic rw, ack, exp_aas;
      {a, rw, ack, own_addr, exp_aas} = VEC[k];
      bus_start();
      chk($sformatf("R2 row %0d busy", k), {7'b0, stat_rdata[5]}, 8'h01);
      bus_byte({a, rw}, ack);
      chk($sformatf("R3 row %0d tc", k), {7'b0, stat_rdata[7]}, 8'h01);
      chk($sformatf("R6 row %0d aas", k), {7'b0, stat_rdata[6]}, {7'b0, exp_aas});
      chk($sformatf("R5 row %0d srw", k), {7'b0, stat_rdata[2]}, {7'b0, rw});
      chk($sformatf("R4 row %0d rxak", k), {7'b0, stat_rdata[0]}, {7'b0, ack});
      chk($sformatf("R8 row %0d flag", k), {7'b0, stat_rdata[1]}, 8'h01);
      chk($sformatf("R9 row %0d irq", k), {7'b0, irq}, 8'h01);
      pulse_ctrl();
      chk($sformatf("R6 row %0d ctrl clears aas", k), {7'b0, stat_rdata[6]}, 8'h00);
      wr_reg(STAT, 8'h00);
      chk($sformatf("R8 row %0d flag cleared", k), {7'b0, stat_rdata[1]}, 8'h00);
      bus_stop();
      chk($sformatf("R2 row %0d idle", k), {7'b0, stat_rdata[5]}, 8'h00);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule